// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block is the serial front end of a port-expander style register file. An external master frames each command by holding chip select low and clocking sixteen bits into the data input, most significant bit first. At the same time, the block shifts the previous contents of its shift register out on the data output. When chip select returns high, the block inspects the captured frame. Bit 15 picks the operation: 0 for a write, 1 for a read. The next seven bits give the register address. The low byte carries the write data, or filler on a read.

A write produces a single-cycle write strobe on the internal register port. A read produces a single-cycle read strobe and copies the addressed register value into the low byte of the shift register. That value then leaves on the data output during the following frame, which may be any command, including a harmless one. A read therefore always costs two frames.

All four serial pins are sampled by a fast system clock through a short synchronizer. The serial clock is detected from its edges, so the serial clock must be several system clocks per phase. Data is captured on a rising serial-clock edge. The output advances on a falling serial-clock edge. While chip select is high, the output is driven to zero.

Top module: `spi_regport`

## Requirements
- R1: After reset the data output is 0, no register strobe is issued, and the shift register holds all zeros, so the first frame shifts out sixteen 0 bits.
- R2: Frame bits are captured most significant first: the first bit clocked in while chip select is low ends up as bit 15 of the frame.
- R3: A frame of exactly 16 bits with bit 15 = 0 issues exactly one write strobe, one cycle long, when chip select rises. The address is bits 14..8 and the data is bits 7..0. No read strobe is issued.
- R4: A frame of exactly 16 bits with bit 15 = 1 issues exactly one read strobe, one cycle long, with the address in bits 14..8. The value returned on the register port replaces bits 7..0 of the shift register.
- R5: During each frame, the data output presents the shift register contents as they stood before the frame, bit 15 first, one bit per serial-clock cycle. After a read, output bits 8 through 15 of the next frame's stream are the register value, most significant first.
- R6: The data output changes only on a falling serial-clock edge, or when chip select falls. It is stable while the serial clock is high.
- R7: A frame that ends after any bit count other than 16 is discarded: no write and no read strobe is issued.
- R8: While chip select is high, the data output is 0, and serial-clock edges neither shift nor count.
- R9: A frame is acted on whether chip select rises while the serial clock is still high after the last bit, or after the serial clock has returned low.
- R10: On a read, the filler byte in bits 7..0 causes no register write and does not appear in the following frame's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_din | input | 1 | Serial data in, most significant bit first |
| spi_dout | output | 1 | Serial data out; 0 while chip select is high |
| rf_wr | output | 1 | One-cycle register write strobe |
| rf_rd | output | 1 | One-cycle register read strobe |
| rf_addr | output | ADDR_W | Register address taken from the captured frame |
| rf_wdata | output | DATA_W | Write data taken from the captured frame |
| rf_rdata | input | DATA_W | Register value returned for rf_addr in the same cycle |

## Verification
A pin change reaches the decision logic after two synchronizer stages. It takes effect on the third system-clock edge, and a registered output such as the data output settles one edge after that. The bench therefore holds every serial-clock phase for six system clocks. It samples the data output just before it raises the serial clock. It checks stability at the end of the high phase, and examines strobe counters, captured addresses and the idle output only after chip select has been high for six clocks. Strobes are counted on the falling system-clock edge of the single cycle in which they occur, so a missing, repeated or spurious strobe changes the count compared after each frame.

// File: rtl/spi_regport_pkg.sv
// Package: shared definitions for the serial register-access port.
// Assumes: frame layout is {op, address, data} with op in the top bit.
package spi_regport_pkg;

    // Operation encoded in the top bit of a frame.
    typedef enum logic {
        OP_WR = 1'b0,
        OP_RD = 1'b1
    } spi_op_e;

    // Bit positions of the serial pins inside the synchronized vector.
    localparam int PIN_DIN  = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_CSN  = 2;
    localparam int PIN_CNT  = 3;

endpackage

// File: rtl/spi_pin_sync.sv
// Module: multi-stage synchronizer for a small vector of asynchronous pins.
// Assumes: STAGES >= 2; each pin is synchronized independently; RST_VAL
// gives the idle level each pin is assumed to hold during reset.
module spi_pin_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    // Purpose: move every pin one stage further along the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= RST_VAL;
            end
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_shift_frame.sv
// Module: edge detection, bit counting, frame shift register and output.
// Assumes: inputs are already synchronized to clk; serial clock phases last
// at least two clk cycles; a load request never coincides with a shift.
module spi_shift_frame #(
    parameter int FRAME_W = 16,
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_s,
    input  logic               sclk_s,
    input  logic               din_s,
    input  logic               load_en,
    input  logic [DATA_W-1:0]  load_data,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic               cs_rise,
    output logic               dout
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic cs_prev;
    logic sclk_prev;
    logic cs_fall;
    logic sclk_rise;
    logic sclk_fall;

    // Purpose: remember last synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_n_s;
            sclk_prev <= sclk_s;
        end
    end

    // Purpose: derive edge events, serial-clock edges only while selected.
    always_comb begin
        cs_fall   = cs_prev & ~cs_n_s;
        cs_rise   = ~cs_prev & cs_n_s;
        sclk_rise = ~cs_n_s & sclk_s & ~sclk_prev;
        sclk_fall = ~cs_n_s & ~sclk_s & sclk_prev;
    end

    // Purpose: count bits received in the current frame, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
        end else if (sclk_rise && (bit_cnt != CNT_MAX)) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Purpose: shift data in MSB first, or take the read preload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '0;
        end else if (sclk_rise) begin
            frame <= {frame[FRAME_W-2:0], din_s};
        end else if (load_en) begin
            frame[DATA_W-1:0] <= load_data;
        end
    end

    // Purpose: present the top bit, advancing on falling serial-clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else if (cs_n_s) begin
            dout <= 1'b0;
        end else if (cs_fall || sclk_fall) begin
            dout <= frame[FRAME_W-1];
        end
    end

endmodule

// File: rtl/spi_frame_decode.sv
// Module: decodes a completed frame into a register write or read request.
// Assumes: cs_rise is a single-cycle pulse; rf_rdata answers rf_addr in the
// same cycle (combinational register-file read).
module spi_frame_decode
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 8,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 6
) (
    input  logic               cs_rise,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   bit_cnt,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic               rf_wr,
    output logic               rf_rd,
    output logic [ADDR_W-1:0]  rf_addr,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic               load_en,
    output logic [DATA_W-1:0]  load_data
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    spi_op_e op;
    logic    accept;

    // Purpose: accept only whole frames and split them by operation.
    always_comb begin
        op        = spi_op_e'(frame[FRAME_W-1]);
        accept    = cs_rise && (bit_cnt == CNT_FULL);
        rf_wr     = accept && (op == OP_WR);
        rf_rd     = accept && (op == OP_RD);
        rf_addr   = frame[FRAME_W-2 -: ADDR_W];
        rf_wdata  = frame[DATA_W-1:0];
        load_en   = rf_rd;
        load_data = rf_rdata;
    end

endmodule

// File: rtl/spi_regport.sv
// Module: top of the serial register-access slave port.
// Assumes: clk runs several times faster than the serial clock; the master
// lowers the serial clock before selecting; the register file answers reads
// combinationally.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_din,
    output logic              spi_dout,
    output logic              rf_wr,
    output logic              rf_rd,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);

    localparam int FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1) + 1;
    localparam logic [PIN_CNT-1:0] PIN_IDLE = PIN_CNT'(1 << PIN_CSN);

    logic [PIN_CNT-1:0] pins_raw;
    logic [PIN_CNT-1:0] pins_s;
    logic               cs_n_s;
    logic               sclk_s;
    logic               din_s;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   bit_cnt;
    logic               cs_rise;
    logic               load_en;
    logic [DATA_W-1:0]  load_data;

    // Purpose: gather the serial pins for the synchronizer.
    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_DIN]  = spi_din;
        pins_raw[PIN_SCLK] = spi_sclk;
        pins_raw[PIN_CSN]  = spi_cs_n;
    end

    spi_pin_sync #(
        .WIDTH   (PIN_CNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    assign cs_n_s = pins_s[PIN_CSN];
    assign sclk_s = pins_s[PIN_SCLK];
    assign din_s  = pins_s[PIN_DIN];

    spi_shift_frame #(
        .FRAME_W (FRAME_W),
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (cs_n_s),
        .sclk_s    (sclk_s),
        .din_s     (din_s),
        .load_en   (load_en),
        .load_data (load_data),
        .frame     (frame),
        .bit_cnt   (bit_cnt),
        .cs_rise   (cs_rise),
        .dout      (spi_dout)
    );

    spi_frame_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_decode (
        .cs_rise   (cs_rise),
        .frame     (frame),
        .bit_cnt   (bit_cnt),
        .rf_rdata  (rf_rdata),
        .rf_wr     (rf_wr),
        .rf_rd     (rf_rd),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata),
        .load_en   (load_en),
        .load_data (load_data)
    );

endmodule

// File: rtl/spi_regport_chk.sv
// Module: protocol checker bound into the serial register-access port.
// Assumes: connected to the synchronized pin levels of the top module.
module spi_regport_chk #(
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_hi,
    input logic             sclk_s,
    input logic             dout,
    input logic             rf_wr,
    input logic             rf_rd,
    input logic [CNT_W-1:0] bit_cnt
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    // R3/R4: strobes only in the cycle chip select is seen rising.
    assert_strobe_at_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr || rf_rd) |-> (cs_hi && !$past(cs_hi)));

    // R3: a write strobe lasts a single cycle.
    assert_write_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |=> !rf_wr);

    // R4: a read strobe lasts a single cycle.
    assert_read_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd |=> !rf_rd);

    // R6: no output change follows a cycle with the serial clock high.
    assert_dout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cs_hi) && $past(sclk_s) && !$past(cs_hi, 2)) |-> $stable(dout));

    // R7: any strobe comes from a frame of exactly full length.
    assert_full_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr || rf_rd) |-> (bit_cnt == CNT_FULL));

    // R8: output is low once deselection has been seen.
    assert_quiet_dout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_hi) |-> !dout);

endmodule

bind spi_regport spi_regport_chk #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_hi   (cs_n_s),
    .sclk_s  (sclk_s),
    .dout    (spi_dout),
    .rf_wr   (rf_wr),
    .rf_rd   (rf_rd),
    .bit_cnt (bit_cnt)
);

// File: tb/sim_spi_regport.sv
// Bench: drives serial frames as a master, models the expected shift
// register and register contents, and compares stream and strobes.
module sim_spi_regport;

    localparam int HP = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n;
    logic       sclk;
    logic       din;
    logic       dout;
    logic       rf_wr;
    logic       rf_rd;
    logic [6:0] rf_addr;
    logic [7:0] rf_wdata;
    logic [7:0] rf_rdata;

    logic [7:0]  rfile [128];
    logic [7:0]  emem  [128];
    logic [15:0] exp_sr;
    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [6:0] last_waddr, last_raddr;
    logic [7:0] last_wdata;
    logic [15:0] rx;
    bit done = 0;

    always #2 clk = ~clk;

    assign rf_rdata = rfile[rf_addr];

    spi_regport u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (sclk),
        .spi_cs_n (cs_n),
        .spi_din  (din),
        .spi_dout (dout),
        .rf_wr    (rf_wr),
        .rf_rd    (rf_rd),
        .rf_addr  (rf_addr),
        .rf_wdata (rf_wdata),
        .rf_rdata (rf_rdata)
    );

    // Register-file stand-in and strobe monitor.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (rf_wr) begin
                wr_cnt++;
                last_waddr = rf_addr;
                last_wdata = rf_wdata;
                rfile[rf_addr] = rf_wdata;
            end
            if (rf_rd) begin
                rd_cnt++;
                last_raddr = rf_addr;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_bit_mask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    endfunction

    // One frame of n bits (bits[n-1] first); end_high raises CS with SCLK high.
    task automatic run_frame(input logic [31:0] bits, input int n,
                             input bit end_high, output logic [15:0] rxo);
        logic [15:0] erx;
        logic [15:0] got;
        logic        held;
        bit          stable_ok;
        int          w0, r0;
        string       rq;
        w0 = wr_cnt; r0 = rd_cnt;
        erx = '0; got = '0; stable_ok = 1;
        bits = bits & next_bit_mask(n);
        @(negedge clk);
        sclk = 1'b0; cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            din = bits[n-1-i];
            erx = {erx[14:0], exp_sr[15]};
            exp_sr = {exp_sr[14:0], bits[n-1-i]};
            repeat (HP) @(negedge clk);
            got = {got[14:0], dout};
            held = dout;
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            if (dout !== held) stable_ok = 0;
            if (!(end_high && i == n - 1)) begin
                sclk = 1'b0;
                repeat (HP) @(negedge clk);
            end
        end
        cs_n = 1'b1;
        repeat (HP) @(negedge clk);
        sclk = 1'b0;
        repeat (2 * HP) @(negedge clk);
        check("R5", {16'd0, got}, {16'd0, erx}, "output stream");
        check("R6", {31'd0, stable_ok}, 32'd1, "output stable while SCLK high");
        check("R8", {31'd0, dout}, 32'd0, "output idle after deselect");
        rq = end_high ? "R9" : "R3";
        if (n == 16) begin
            if (!bits[15]) begin
                check(rq, wr_cnt - w0, 1, "write strobe count");
                check("R3", rd_cnt - r0, 0, "no read on write");
                check("R3", {25'd0, last_waddr}, {25'd0, bits[14:8]}, "write address");
                check("R3", {24'd0, last_wdata}, {24'd0, bits[7:0]}, "write data");
                emem[bits[14:8]] = bits[7:0];
            end else begin
                check(end_high ? "R9" : "R4", rd_cnt - r0, 1, "read strobe count");
                check("R10", wr_cnt - w0, 0, "no write on read");
                check("R4", {25'd0, last_raddr}, {25'd0, bits[14:8]}, "read address");
                exp_sr[7:0] = emem[bits[14:8]];
            end
        end else begin
            check("R7", wr_cnt - w0, 0, "short/long frame write");
            check("R7", rd_cnt - r0, 0, "short/long frame read");
        end
        rxo = got;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] b;
        int n;
        bit eh;
        void'($urandom(32'd2718));
        for (int i = 0; i < 128; i++) begin
            rfile[i] = 8'($urandom);
            emem[i]  = rfile[i];
        end
        exp_sr = '0;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state.
        check("R1", {31'd0, dout}, 32'd0, "output after reset");
        check("R1", wr_cnt + rd_cnt, 0, "no strobes after reset");
        run_frame(32'h0000_1311, 16, 1'b0, rx);
        check("R1", {16'd0, rx}, 32'd0, "first frame shifts out zeros");

        // R2: MSB-first capture, seen as echo in the next frame.
        run_frame(32'h0000_25C3, 16, 1'b0, rx);
        run_frame(32'h0000_7F00, 16, 1'b0, rx);
        check("R2", {16'd0, rx}, 32'h0000_25C3, "echo of MSB-first frame");

        // R4/R10: write 0x40, read it with filler, follow with another read.
        run_frame(32'h0000_409E, 16, 1'b0, rx);
        run_frame(32'h0000_C05A, 16, 1'b0, rx);
        run_frame(32'h0000_A500, 16, 1'b0, rx);
        check("R4", {24'd0, rx[7:0]}, 32'h9E, "read data in second byte");
        check("R10", {24'd0, rx[15:8]}, 32'hC0, "upper byte echoes command");
        run_frame(32'h0000_0000, 16, 1'b0, rx);
        check("R4", {24'd0, rx[7:0]}, {24'd0, emem[7'h25]}, "back-to-back read data");

        // R7: wrong lengths.
        run_frame(32'h0000_0ABC, 12, 1'b0, rx);
        run_frame(32'h0001_2345, 17, 1'b0, rx);
        run_frame(32'h0000_8000, 1, 1'b1, rx);

        // R9: deselect with SCLK still high.
        run_frame(32'h0000_1C77, 16, 1'b1, rx);
        run_frame(32'h0000_9C00, 16, 1'b1, rx);
        run_frame(32'h0000_0000, 16, 1'b1, rx);
        check("R9", {24'd0, rx[7:0]}, 32'h77, "read after high-SCLK deselect");

        // R8: SCLK activity while deselected is ignored.
        for (int i = 0; i < 10; i++) begin
            din = 1'($urandom);
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            check("R8", {31'd0, dout}, 32'd0, "output while deselected");
            sclk = 1'b0;
            repeat (HP) @(negedge clk);
        end
        run_frame(32'h0000_3355, 16, 1'b0, rx);

        // Random mix.
        for (int k = 0; k < 60; k++) begin
            b  = $urandom;
            n  = ($urandom % 8 == 0) ? (8 + int'($urandom % 12)) : 16;
            eh = 1'($urandom);
            run_frame(b, n, eh, rx);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule